// File: doc/BRIEF.md
# Transmit Cell Error Inserter with Input Parity Check

This block sits in the byte-wide transmit path of fixed 53-byte cells. Each byte arrives with a start-of-cell flag and an odd-parity bit on a valid/ready stream. The byte leaves one register stage later on a second valid/ready stream, with the start-of-cell flag kept aligned.

On the way through, the block can corrupt a cell on purpose. It can invert the lowest bit of the header check byte, which is the fifth byte of the cell. It can also invert the lowest bit of the final payload byte, which is the 53rd byte. Either corruption can be used on its own, or both together. This lets error detection at the far end, or in a local loopback, be exercised.

When the checking enable is set, the block also checks the parity of every accepted input byte. Each byte that fails the check raises a one-cycle error pulse, which is meant for a sticky interrupt bit outside the block. The parity bit that goes out is regenerated over the outgoing byte, so a deliberately corrupted byte still carries correct parity.

Back-pressure rules:
- An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being emptied in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output byte and its flags stay frozen.

Top module: `tx_cell_err_inject`

## Requirements
- R1: An input byte accepted at a clock edge appears on `out_data`, with its start flag on `out_sop`, with `out_valid` high from that same edge. Bytes leave in the order they were accepted, and none is lost or repeated.
- R2: `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sop` hold their values.
- R3: The byte index is set as follows:
  - An accepted byte with `in_sop` high has index 0, even in the middle of a cell.
  - Each later accepted byte has the previous index plus 1, up to 52.
  - Bytes accepted after reset and before any start flag, and bytes after index 52, are outside any cell and are never altered.
- R4: When `ins_hec_err` is high as the byte with index 4 is accepted, bit 0 of that byte is inverted on output.
- R5: When `ins_pay_err` is high as the byte with index 52 is accepted, bit 0 of that byte is inverted on output.
- R6: Both insertions may be enabled together. Each then applies to every cell independently, and no other byte or bit is altered.
- R7: The parity check works as follows:
  - An input byte has good parity when `in_data` and `in_par` together hold an odd number of ones.
  - When `par_chk_en` is high as a byte with bad parity is accepted, `par_err` is high for exactly the one cycle after that edge.
  - When `par_chk_en` is low, bad parity raises no pulse.
- R8: `out_par` is the odd-parity bit of `out_data` as it leaves the block, including any inverted bit.
- R9: While `rst_n` is low, `out_valid` and `par_err` are low, and the byte counter is outside any cell.
- R10: With both insertion controls low, every byte passes through unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_par | input | 1 | Odd-parity bit of the input byte |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte, possibly with bit 0 inverted |
| out_par | output | 1 | Regenerated odd-parity bit of `out_data` |
| out_sop | output | 1 | Output byte is the first byte of a cell |
| par_chk_en | input | 1 | Enables the input parity check |
| ins_hec_err | input | 1 | Inverts bit 0 of byte index 4 of each cell |
| ins_pay_err | input | 1 | Inverts bit 0 of byte index 52 of each cell |
| par_err | output | 1 | One-cycle pulse for an input byte with bad parity |

## Verification
A byte counter that is off by one moves the corruption onto a neighbouring byte. This shows up as a data mismatch on the first cell with insertion enabled, at most 53 bytes after the start flag. A counter that fails to restart on a mid-cell start flag, or that keeps counting past the cell, corrupts a byte outside the index-4 or index-52 positions. A stuck or mistimed parity pulse is caught on the accepted byte that follows it. A lost or duplicated output byte breaks the scoreboard order as soon as `out_ready` is withdrawn.

// File: rtl/tx_cell_pkg.sv
package tx_cell_pkg;
  typedef struct packed {
    logic hec;
    logic pay;
  } ins_ctrl_t;

  function automatic logic odd_par_bit(input logic [7:0] d);
    return ~^d;
  endfunction
endpackage

// File: rtl/tx_byte_index.sv
module tx_byte_index #(
  parameter int CELL_LEN = 53,
  localparam int IDX_W = $clog2(CELL_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sop,
  output logic [IDX_W-1:0] cur_idx,
  output logic             in_cell
);
  localparam logic [IDX_W-1:0] IDLE = IDX_W'(CELL_LEN);
  logic [IDX_W-1:0] cnt_q;

  always_comb begin
    cur_idx = sop ? '0 : cnt_q;
    in_cell = (cur_idx != IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= IDLE;
    else if (take) cnt_q <= in_cell ? cur_idx + 1'b1 : IDLE;
  end
endmodule

// File: rtl/tx_par_check.sv
module tx_par_check #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              err
);
  logic bad;
  assign bad = en && !(^{data, par});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else err <= take && bad;
  end
endmodule

// File: rtl/tx_flip_mask.sv
module tx_flip_mask
  import tx_cell_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CELL_LEN = 53,
  parameter int HEC_IDX  = 4,
  parameter int FLIP_BIT = 0,
  localparam int IDX_W = $clog2(CELL_LEN + 1)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_cell,
  input  ins_ctrl_t         ctrl,
  output logic [DATA_W-1:0] mask
);
  logic hit_hec, hit_pay;
  assign hit_hec = ctrl.hec && in_cell && (idx == IDX_W'(HEC_IDX));
  assign hit_pay = ctrl.pay && in_cell && (idx == IDX_W'(CELL_LEN - 1));

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == FLIP_BIT) begin : g_flip
      assign mask[b] = hit_hec | hit_pay;
    end else begin : g_keep
      assign mask[b] = 1'b0;
    end
  end
endmodule

// File: rtl/tx_out_stage.sv
module tx_out_stage
  import tx_cell_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_par
);
  assign in_ready = !out_valid || out_ready;
  assign out_par  = ~^out_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_sop   <= in_sop;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_cell_err_inject.sv
module tx_cell_err_inject
  import tx_cell_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CELL_LEN = 53,
  parameter int HEC_IDX  = 4,
  parameter int FLIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par,
  input  logic              in_sop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par,
  output logic              out_sop,
  input  logic              par_chk_en,
  input  logic              ins_hec_err,
  input  logic              ins_pay_err,
  output logic              par_err
);
  localparam int IDX_W = $clog2(CELL_LEN + 1);

  logic              take;
  logic [IDX_W-1:0]  idx;
  logic              in_cell;
  logic [DATA_W-1:0] mask;
  ins_ctrl_t         ctrl;

  assign take     = in_valid && in_ready;
  assign ctrl.hec = ins_hec_err;
  assign ctrl.pay = ins_pay_err;

  tx_byte_index #(.CELL_LEN(CELL_LEN)) u_idx (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(in_sop),
    .cur_idx(idx), .in_cell(in_cell)
  );

  tx_par_check #(.DATA_W(DATA_W)) u_par (
    .clk(clk), .rst_n(rst_n), .take(take), .en(par_chk_en),
    .data(in_data), .par(in_par), .err(par_err)
  );

  tx_flip_mask #(.DATA_W(DATA_W), .CELL_LEN(CELL_LEN), .HEC_IDX(HEC_IDX),
                 .FLIP_BIT(FLIP_BIT)) u_mask (
    .idx(idx), .in_cell(in_cell), .ctrl(ctrl), .mask(mask)
  );

  tx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data ^ mask), .in_sop(in_sop),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_par(out_par)
  );
endmodule

// File: rtl/tx_cell_err_inject_chk.sv
module tx_cell_err_inject_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              par_chk_en,
  input logic              par_err
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop));

  assert_accept_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_appear_needs_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  assert_perr_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(par_chk_en));

  assert_perr_needs_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(in_valid && in_ready));
endmodule

bind tx_cell_err_inject tx_cell_err_inject_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .par_chk_en(par_chk_en), .par_err(par_err)
);

// File: tb/tb_tx_cell_err_inject.sv
`timescale 1ns/1ps
module tb_tx_cell_err_inject;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_par = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_par, out_sop, par_err;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic par_chk_en = 1'b0, ins_hec_err = 1'b0, ins_pay_err = 1'b0;

  always #2.5 clk = ~clk;

  tx_cell_err_inject dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_par(in_par), .in_sop(in_sop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_par(out_par), .out_sop(out_sop), .par_chk_en(par_chk_en),
    .ins_hec_err(ins_hec_err), .ins_pay_err(ins_pay_err), .par_err(par_err)
  );

  int checks = 0, fails = 0;
  logic [8:0] expq[$];
  int m_idx = 53;
  bit stall = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: presents one byte, waits for acceptance, records expectation.
  task automatic send_byte(input logic [7:0] d, input bit sop, input bit badpar);
    logic [7:0] e;
    bit exp_perr;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = sop;
    in_par = badpar ? ^d : ~^d;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    // R3 model of the byte index
    if (sop) m_idx = 0;
    e = d;
    if (m_idx < 53) begin
      if (ins_hec_err && m_idx == 4) e[0] = ~e[0];   // R4
      if (ins_pay_err && m_idx == 52) e[0] = ~e[0];  // R5
      m_idx++;
    end
    exp_perr = par_chk_en && badpar;
    expq.push_back({sop, e});
    @(posedge clk);
    #1;
    chk(par_err == exp_perr, "R7 parity pulse", par_err, exp_perr);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cell(input int len, input int seed, input int bad_every);
    for (int i = 0; i < len; i++) begin
      send_byte(8'(seed + i * 7), i == 0, bad_every != 0 && (i % bad_every) == 3);
      if (i % 5 == 2) idle();
    end
    idle();
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: drives back-pressure and pops the scoreboard.
  initial begin
    logic [8:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R1 unexpected byte", out_data, 0);
        end else begin
          e = expq.pop_front();
          chk({out_sop, out_data} == e, "R1/R4/R5/R6/R10 data", {out_sop, out_data}, e);
          chk(out_par == ~^out_data, "R8 out parity", out_par, ~^out_data);
        end
      end
    end
  end

  // R2: output held while stalled
  logic [8:0] held;
  bit was_stall = 1'b0;
  always @(negedge clk) begin
    #1.5;
    if (rst_n && was_stall)
      chk(out_valid && {out_sop, out_data} == held, "R2 hold", {out_sop, out_data}, held);
    was_stall = out_valid && !out_ready;
    held = {out_sop, out_data};
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    chk(par_err == 1'b0, "R9 par_err in reset", par_err, 0);
    chk(in_ready == 1'b1, "R2 ready when empty", in_ready, 1);
    rst_n = 1'b1;
    // R3: bytes before any start flag are outside a cell
    ins_hec_err = 1'b1; ins_pay_err = 1'b1;
    for (int i = 0; i < 10; i++) send_byte(8'h40 + 8'(i), 1'b0, 1'b0);
    idle(); drain();
    // R10: plain cell
    ins_hec_err = 1'b0; ins_pay_err = 1'b0;
    send_cell(53, 8'h11, 0); drain();
    // R4 with back-pressure (R2)
    stall = 1'b1; ins_hec_err = 1'b1;
    send_cell(53, 8'h22, 0); drain();
    // R5
    ins_hec_err = 1'b0; ins_pay_err = 1'b1;
    send_cell(53, 8'h33, 0); drain();
    // R6 both, two cells back to back
    ins_hec_err = 1'b1;
    send_cell(53, 8'h44, 0);
    send_cell(53, 8'h55, 0); drain();
    // R3: mid-cell restart, then overlong cell
    for (int i = 0; i < 20; i++) send_byte(8'(i), i == 0, 1'b0);
    send_cell(60, 8'h66, 0); drain();
    // R7 parity check enabled, then disabled
    stall = 1'b0; ins_hec_err = 1'b0; ins_pay_err = 1'b0;
    par_chk_en = 1'b1;
    send_cell(53, 8'h77, 7); drain();
    par_chk_en = 1'b0;
    send_cell(53, 8'h88, 4); drain();
    chk(expq.size() == 0, "R1 all bytes delivered", expq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule